// File: doc/BRIEF.md
# Programmable Bus Wait-State Controller

This block decides how many bus clocks each memory access lasts on a 20-bit microcontroller address bus and produces the chip-select strobes, a cycle-active flag and a one-clock completion pulse for that access. An access is requested with `req_i` and an address. The controller decodes the address into one of three internal areas (special-function registers, RAM, ROM) or one of four external chip-select windows. It then works out the cycle length from four inputs: a global wait bit, four per-window wait bits, a per-window flag marking a multiplexed address/data bus, and a fixed rule that the register area is always slow. External devices can stretch a cycle further by holding the ready line low.

Two write ports hold the configuration. The chip-select control write stores the four per-window wait bits. The mode write stores the global wait bit. The configuration, region and bus type are captured on the clock edge that accepts a request, so a write made during a cycle only affects later cycles.

The sequencer has four states. `S_IDLE` waits for a request. `S_ADDR` is the address phase of a multiplexed access. `S_WAIT` covers the inserted wait clocks. `S_LAST` is the final clock, on which ready is sampled. The transitions are:
- IDLE→ADDR on a request to a multiplexed window.
- IDLE→WAIT on a non-multiplexed request that needs waits.
- IDLE→LAST on a request with no waits.
- ADDR→WAIT, or ADDR→LAST when no waits are loaded.
- WAIT→WAIT while wait clocks remain, then WAIT→LAST.
- LAST→LAST while an external device holds ready low.
- LAST→IDLE when the cycle completes.

Top module: `bus_wait_ctrl`

## Requirements
- R1: After reset the controller is idle: `active_o` and `done_o` are low, all `cs_n_o` bits are high, and the global and per-window wait bits are cleared, so a plain external access at 0xC0000 takes 1 clock.
- R2: An access in the register area 0x00000–0x003FF always takes 2 clocks, whatever the global wait bit says.
- R3: Accesses to RAM (0x00400–0x02BFF) and ROM (0xE8000–0xFFFFF) take 1 clock with the global wait bit clear and 2 clocks with it set.
- R4: With the global bit clear, an access to a non-multiplexed window takes 2 clocks if that window's wait bit is set and 1 clock otherwise. The wait bits sit in bits 4, 5, 6 and 7 of the chip-select control write data, for windows 0, 1, 2 and 3. The windows are: window 0 at 0xC0000–0xE7FFF, window 1 at 0x80000–0xBFFFF, window 2 at 0x40000–0x7FFFF, and window 3 at 0x02C00–0x3FFFF.
- R5: The global wait bit (bit 7 of the mode write data) makes every non-multiplexed window take 2 clocks, even when all per-window bits are clear.
- R6: An access to a window whose `bus_mux_i` bit is set takes 3 clocks, whatever the wait bits say.
- R7: For external windows, ready is sampled on the last programmed clock. Each clock on which it is low adds one clock, and `done_o` is high only on the clock where ready is high.
- R8: Ready has no effect on accesses to the register, RAM or ROM areas.
- R9: A configuration write on the accepting edge, or later during the cycle, does not change the length of the cycle in progress. It does apply to the next access.
- R10: During an external access exactly the strobe of the decoded window is low for the whole cycle. No strobe is low for internal areas or while idle.
- R11: `done_o` pulses once per access, on its last clock. A request seen while a cycle is in progress is ignored, and the controller returns to idle for one clock before it accepts the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, accepted when idle |
| addr_i | input | 20 | Access address |
| csctl_we_i | input | 1 | Write strobe for the chip-select control value |
| csctl_wd_i | input | 8 | Chip-select control data; bits 7:4 are the wait bits of windows 3..0 |
| mode_we_i | input | 1 | Write strobe for the mode value |
| mode_wd_i | input | 8 | Mode data; bit 7 is the global wait bit |
| bus_mux_i | input | 4 | Per-window multiplexed-bus flag |
| rdy_i | input | 1 | Ready from external device, high = ready |
| cs_n_o | output | 4 | Active-low chip-select strobes, one per window |
| active_o | output | 1 | High while an access cycle is in progress |
| done_o | output | 1 | High on the final clock of an access |

## Verification
Two pairs of events can land in the same clock. First, a configuration write can arrive on the same edge that accepts a request. The bench stages a wait-bit write together with the request and expects the old, shorter length, then the new length on the following access. Second, ready can rise exactly on the last programmed clock, or a request can still be held high while the previous cycle completes. Here a behavioural model of cycle lengths and strobes is compared every clock, and ready is released after a chosen number of low samples. The measured length must equal the programmed length plus that count.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_SFR,
        RG_RAM,
        RG_ROM,
        RG_EXT
    } bwc_region_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ADDR,
        S_WAIT,
        S_LAST
    } bwc_state_e;

endpackage

// File: rtl/bwc_cfg_regs.sv
module bwc_cfg_regs #(
    parameter int N_CS     = 4,
    parameter int CFG_W    = 8,
    parameter int CSW_LSB  = 4,
    parameter int GLOB_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csctl_we_i,
    input  logic [CFG_W-1:0] csctl_wd_i,
    input  logic             mode_we_i,
    input  logic [CFG_W-1:0] mode_wd_i,
    output logic [N_CS-1:0]  csw_o,
    output logic             glob_o
);

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{csctl_wd_i, mode_wd_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csw_o  <= '0;
            glob_o <= 1'b0;
        end else begin
            if (csctl_we_i) begin
                csw_o <= csctl_wd_i[CSW_LSB +: N_CS];
            end
            if (mode_we_i) begin
                glob_o <= mode_wd_i[GLOB_BIT];
            end
        end
    end

    // R9: stored wait bits only move on a write
    p_cfg_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (!csctl_we_i && !mode_we_i) |=> ($stable(csw_o) && $stable(glob_o)));

endmodule

// File: rtl/bwc_addr_decode.sv
module bwc_addr_decode
    import bwc_pkg::*;
#(
    parameter int                     ADDR_W    = 20,
    parameter int                     N_CS      = 4,
    parameter logic [ADDR_W-1:0]      SFR_LAST  = 20'h003FF,
    parameter logic [ADDR_W-1:0]      RAM_LAST  = 20'h02BFF,
    parameter logic [ADDR_W-1:0]      ROM_FIRST = 20'hE8000,
    parameter logic [N_CS*ADDR_W-1:0] CS_FIRST  = {20'h02C00, 20'h40000, 20'h80000, 20'hC0000},
    parameter logic [N_CS*ADDR_W-1:0] CS_LAST   = {20'h3FFFF, 20'h7FFFF, 20'hBFFFF, 20'hE7FFF}
) (
    input  logic [ADDR_W-1:0] addr_i,
    output bwc_region_e       kind_o,
    output logic [N_CS-1:0]   cs_hit_o
);

    logic [N_CS-1:0] win;
    logic            in_sfr;
    logic            in_ram;
    logic            in_rom;

    genvar gi;
    generate
        for (gi = 0; gi < N_CS; gi++) begin : g_win
            assign win[gi] = (addr_i >= CS_FIRST[gi*ADDR_W +: ADDR_W]) &&
                             (addr_i <= CS_LAST[gi*ADDR_W +: ADDR_W]);
        end
    endgenerate

    assign in_sfr = (addr_i <= SFR_LAST);
    assign in_ram = !in_sfr && (addr_i <= RAM_LAST);
    assign in_rom = (addr_i >= ROM_FIRST);

    always_comb begin
        cs_hit_o = '0;
        if (!in_sfr && !in_ram && !in_rom) begin
            for (int i = N_CS - 1; i >= 0; i--) begin
                if (win[i]) begin
                    cs_hit_o    = '0;
                    cs_hit_o[i] = 1'b1;
                end
            end
        end
    end

    always_comb begin
        if (in_sfr) begin
            kind_o = RG_SFR;
        end else if (in_ram) begin
            kind_o = RG_RAM;
        end else if (in_rom) begin
            kind_o = RG_ROM;
        end else if (|cs_hit_o) begin
            kind_o = RG_EXT;
        end else begin
            kind_o = RG_NONE;
        end
    end

    // R10: at most one window wins the decode
    always_comb begin
        p_hit_onehot_r10 : assert ($onehot0(cs_hit_o));
    end

endmodule

// File: rtl/bwc_len_sel.sv
module bwc_len_sel
    import bwc_pkg::*;
#(
    parameter int N_CS      = 4,
    parameter int WAIT_CLKS = 1,
    parameter int CNT_W     = 1
) (
    input  bwc_region_e      kind_i,
    input  logic [N_CS-1:0]  cs_hit_i,
    input  logic [N_CS-1:0]  csw_i,
    input  logic             glob_i,
    input  logic [N_CS-1:0]  mux_i,
    output logic [CNT_W-1:0] waits_o,
    output logic             mux_phase_o,
    output logic             rdy_use_o
);

    localparam logic [CNT_W-1:0] WAIT_VAL = CNT_W'(WAIT_CLKS);

    logic sel_w;
    logic sel_mux;

    assign sel_w   = |(cs_hit_i & csw_i);
    assign sel_mux = |(cs_hit_i & mux_i);

    always_comb begin
        waits_o     = '0;
        mux_phase_o = 1'b0;
        rdy_use_o   = 1'b0;
        unique case (kind_i)
            RG_SFR: begin
                waits_o = WAIT_VAL;
            end
            RG_RAM, RG_ROM: begin
                waits_o = glob_i ? WAIT_VAL : '0;
            end
            RG_EXT: begin
                rdy_use_o   = 1'b1;
                mux_phase_o = sel_mux;
                waits_o     = (glob_i || sel_w || sel_mux) ? WAIT_VAL : '0;
            end
            RG_NONE: begin
                waits_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/bwc_seq.sv
module bwc_seq
    import bwc_pkg::*;
#(
    parameter int N_CS      = 4,
    parameter int WAIT_CLKS = 1,
    parameter int CNT_W     = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [CNT_W-1:0] waits_i,
    input  logic             mux_phase_i,
    input  logic             rdy_use_i,
    input  logic [N_CS-1:0]  cs_hit_i,
    input  logic             rdy_i,
    output logic [N_CS-1:0]  cs_n_o,
    output logic             active_o,
    output logic             done_o
);

    bwc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [N_CS-1:0]  cs_q;
    logic             ext_q;
    logic             accept;
    logic             fin;

    assign fin = (state_q == S_LAST) && (!ext_q || rdy_i);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        accept  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req_i) begin
                    accept = 1'b1;
                    cnt_d  = waits_i;
                    if (mux_phase_i) begin
                        state_d = S_ADDR;
                    end else if (waits_i != '0) begin
                        state_d = S_WAIT;
                    end else begin
                        state_d = S_LAST;
                    end
                end
            end
            S_ADDR: begin
                state_d = (cnt_q != '0) ? S_WAIT : S_LAST;
            end
            S_WAIT: begin
                if (cnt_q <= CNT_W'(1)) begin
                    state_d = S_LAST;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            S_LAST: begin
                if (fin) begin
                    state_d = S_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            cs_q    <= '0;
            ext_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (accept) begin
                cs_q  <= cs_hit_i;
                ext_q <= rdy_use_i;
            end
        end
    end

    always_comb begin
        active_o = (state_q != S_IDLE);
        done_o   = fin;
        cs_n_o   = active_o ? ~cs_q : '1;
    end

    // R1: idle means quiet strobes and no completion
    p_idle_quiet_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> (&cs_n_o && !done_o));

    // R10: strobes never overlap
    p_cs_onehot_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));

    // R10: strobe held for the whole cycle
    p_cs_stable_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !done_o) |=> (active_o && $stable(cs_n_o)));

    // R11: completion leaves one idle clock
    p_done_ends_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !active_o);

    // R7: a low ready holds the final clock
    p_rdy_stretch_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LAST && ext_q && !rdy_i) |=> (state_q == S_LAST));

    // R6: address phase is followed by the wait clock
    generate
        if (WAIT_CLKS > 0) begin : g_mux_chk
            p_addr_then_wait_r6 : assert property (@(posedge clk) disable iff (!rst_n)
                (state_q == S_ADDR) |=> (state_q == S_WAIT));
        end
    endgenerate

endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
    import bwc_pkg::*;
#(
    parameter int                     ADDR_W    = 20,
    parameter int                     N_CS      = 4,
    parameter int                     WAIT_CLKS = 1,
    parameter int                     CFG_W     = 8,
    parameter int                     CSW_LSB   = 4,
    parameter int                     GLOB_BIT  = 7,
    parameter logic [ADDR_W-1:0]      SFR_LAST  = 20'h003FF,
    parameter logic [ADDR_W-1:0]      RAM_LAST  = 20'h02BFF,
    parameter logic [ADDR_W-1:0]      ROM_FIRST = 20'hE8000,
    parameter logic [N_CS*ADDR_W-1:0] CS_FIRST  = {20'h02C00, 20'h40000, 20'h80000, 20'hC0000},
    parameter logic [N_CS*ADDR_W-1:0] CS_LAST   = {20'h3FFFF, 20'h7FFFF, 20'hBFFFF, 20'hE7FFF}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              csctl_we_i,
    input  logic [CFG_W-1:0]  csctl_wd_i,
    input  logic              mode_we_i,
    input  logic [CFG_W-1:0]  mode_wd_i,
    input  logic [N_CS-1:0]   bus_mux_i,
    input  logic              rdy_i,
    output logic [N_CS-1:0]   cs_n_o,
    output logic              active_o,
    output logic              done_o
);

    localparam int CNT_W = (WAIT_CLKS < 1) ? 1 : $clog2(WAIT_CLKS + 1);

    logic [N_CS-1:0]  csw;
    logic             glob;
    bwc_region_e      kind;
    logic [N_CS-1:0]  cs_hit;
    logic [CNT_W-1:0] waits;
    logic             mux_phase;
    logic             rdy_use;

    bwc_cfg_regs #(
        .N_CS     (N_CS),
        .CFG_W    (CFG_W),
        .CSW_LSB  (CSW_LSB),
        .GLOB_BIT (GLOB_BIT)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .csctl_we_i (csctl_we_i),
        .csctl_wd_i (csctl_wd_i),
        .mode_we_i  (mode_we_i),
        .mode_wd_i  (mode_wd_i),
        .csw_o      (csw),
        .glob_o     (glob)
    );

    bwc_addr_decode #(
        .ADDR_W    (ADDR_W),
        .N_CS      (N_CS),
        .SFR_LAST  (SFR_LAST),
        .RAM_LAST  (RAM_LAST),
        .ROM_FIRST (ROM_FIRST),
        .CS_FIRST  (CS_FIRST),
        .CS_LAST   (CS_LAST)
    ) u_dec (
        .addr_i   (addr_i),
        .kind_o   (kind),
        .cs_hit_o (cs_hit)
    );

    bwc_len_sel #(
        .N_CS      (N_CS),
        .WAIT_CLKS (WAIT_CLKS),
        .CNT_W     (CNT_W)
    ) u_len (
        .kind_i      (kind),
        .cs_hit_i    (cs_hit),
        .csw_i       (csw),
        .glob_i      (glob),
        .mux_i       (bus_mux_i),
        .waits_o     (waits),
        .mux_phase_o (mux_phase),
        .rdy_use_o   (rdy_use)
    );

    bwc_seq #(
        .N_CS      (N_CS),
        .WAIT_CLKS (WAIT_CLKS),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .waits_i     (waits),
        .mux_phase_i (mux_phase),
        .rdy_use_i   (rdy_use),
        .cs_hit_i    (cs_hit),
        .rdy_i       (rdy_i),
        .cs_n_o      (cs_n_o),
        .active_o    (active_o),
        .done_o      (done_o)
    );

endmodule

// File: tb/bus_wait_ctrl_tb.sv
module bus_wait_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [19:0] addr_i = '0;
    logic        csctl_we_i = 1'b0;
    logic [7:0]  csctl_wd_i = '0;
    logic        mode_we_i = 1'b0;
    logic [7:0]  mode_wd_i = '0;
    logic [3:0]  bus_mux_i = '0;
    logic        rdy_i = 1'b1;
    logic [3:0]  cs_n_o;
    logic        active_o;
    logic        done_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_wait_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .addr_i     (addr_i),
        .csctl_we_i (csctl_we_i),
        .csctl_wd_i (csctl_wd_i),
        .mode_we_i  (mode_we_i),
        .mode_wd_i  (mode_wd_i),
        .bus_mux_i  (bus_mux_i),
        .rdy_i      (rdy_i),
        .cs_n_o     (cs_n_o),
        .active_o   (active_o),
        .done_o     (done_o)
    );

    int    checks = 0;
    int    fails = 0;
    string cur_tag = "R1";
    bit    finished = 1'b0;

    // staged inputs
    logic        s_rst_n = 1'b0;
    logic        s_req = 1'b0;
    logic [19:0] s_addr = '0;
    logic        s_rdy = 1'b1;
    logic        s_csctl_we = 1'b0;
    logic [7:0]  s_csctl_wd = '0;
    logic        s_mode_we = 1'b0;
    logic [7:0]  s_mode_wd = '0;
    logic [3:0]  s_mux = '0;

    // reference model
    bit         m_busy;
    int         m_left;
    bit         m_ext;
    int         m_cs;
    bit         m_glob;
    logic [3:0] m_csw;
    bit         m_dn;

    function automatic int window_of(logic [19:0] a);
        if (a <= 20'h02BFF || a >= 20'hE8000) return -1;
        if (a >= 20'hC0000) return 0;
        if (a >= 20'h80000) return 1;
        if (a >= 20'h40000) return 2;
        return 3;
    endfunction

    function automatic int len_of(logic [19:0] a, bit g, logic [3:0] w, logic [3:0] mx);
        int c;
        if (a <= 20'h003FF) return 2;
        c = window_of(a);
        if (c < 0) return g ? 2 : 1;
        if (mx[c]) return 3;
        return (g || w[c]) ? 2 : 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_left = 0; m_ext = 1'b0; m_cs = -1;
            m_glob = 1'b0; m_csw = '0;
        end else begin
            m_dn = m_busy && (m_left == 1) && (!m_ext || rdy_i);
            if (m_busy) begin
                if (m_left > 1) m_left = m_left - 1;
                else if (m_dn) m_busy = 1'b0;
            end else if (req_i) begin
                m_busy = 1'b1;
                m_left = len_of(addr_i, m_glob, m_csw, bus_mux_i);
                m_cs   = window_of(addr_i);
                m_ext  = (m_cs >= 0);
            end
            if (csctl_we_i) m_csw = csctl_wd_i[7:4];
            if (mode_we_i)  m_glob = mode_wd_i[7];
        end
    end

    task automatic tick();
        logic [3:0] e_cs;
        bit         e_done;
        @(negedge clk);
        rst_n = s_rst_n; req_i = s_req; addr_i = s_addr; rdy_i = s_rdy;
        csctl_we_i = s_csctl_we; csctl_wd_i = s_csctl_wd;
        mode_we_i = s_mode_we; mode_wd_i = s_mode_wd; bus_mux_i = s_mux;
        s_csctl_we = 1'b0; s_mode_we = 1'b0;
        #1;
        e_cs   = (m_busy && m_cs >= 0) ? ~(4'b0001 << m_cs) : 4'hF;
        e_done = m_busy && (m_left == 1) && (!m_ext || rdy_i);
        checks++;
        if (active_o !== m_busy || done_o !== e_done || cs_n_o !== e_cs) begin
            fails++;
            $display("FAIL %s per-clock: active=%0b done=%0b cs_n=%h expected active=%0b done=%0b cs_n=%h",
                     cur_tag, active_o, done_o, cs_n_o, m_busy, e_done, e_cs);
        end
    endtask

    task automatic wr_cs(logic [7:0] v);
        s_csctl_we = 1'b1; s_csctl_wd = v; tick();
    endtask

    task automatic wr_mode(logic [7:0] v);
        s_mode_we = 1'b1; s_mode_wd = v; tick();
    endtask

    // lows < 0: ready held low for the whole access
    task automatic run_access(logic [19:0] a, int lows, int exp_len, string tag);
        int n;
        cur_tag = tag;
        s_req = 1'b1; s_addr = a; s_rdy = 1'b1;
        tick();
        s_req = 1'b0;
        n = 0;
        while (1) begin
            if (lows < 0) s_rdy = 1'b0;
            else s_rdy = ((n + 1) >= (exp_len + ((lows < 0) ? 0 : lows)));
            tick();
            n++;
            if (done_o === 1'b1 || n > 40) break;
        end
        checks++;
        if (n != exp_len + ((lows < 0) ? 0 : lows)) begin
            fails++;
            $display("FAIL %s cycle length at %h: actual=%0d expected=%0d",
                     tag, a, n, exp_len + ((lows < 0) ? 0 : lows));
        end
        s_rdy = 1'b1;
        tick();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int pulses;
        // R1 reset state
        cur_tag = "R1";
        s_rst_n = 1'b0;
        repeat (3) tick();
        s_rst_n = 1'b1;
        repeat (2) tick();
        checks++;
        if (active_o !== 1'b0 || done_o !== 1'b0 || cs_n_o !== 4'hF) begin
            fails++;
            $display("FAIL R1 reset: active=%0b done=%0b cs_n=%h expected 0 0 f", active_o, done_o, cs_n_o);
        end
        run_access(20'hC0000, 0, 1, "R1");
        run_access(20'h01000, 0, 1, "R1");

        // R2 register area
        run_access(20'h00010, 0, 2, "R2");
        run_access(20'h003FF, 0, 2, "R2");
        wr_mode(8'h80);
        run_access(20'h00200, 0, 2, "R2");
        wr_mode(8'h00);

        // R3 RAM / ROM
        run_access(20'h00400, 0, 1, "R3");
        run_access(20'h02BFF, 0, 1, "R3");
        run_access(20'hE8000, 0, 1, "R3");
        run_access(20'hFFFFF, 0, 1, "R3");
        wr_mode(8'h80);
        run_access(20'h01000, 0, 2, "R3");
        run_access(20'hF0000, 0, 2, "R3");
        wr_mode(8'h00);

        // R4 / R10 per-window wait bits and strobes
        wr_cs(8'b0101_0000);
        run_access(20'hC0000, 0, 2, "R4/R10");
        run_access(20'h80000, 0, 1, "R4/R10");
        run_access(20'h40000, 0, 2, "R4/R10");
        run_access(20'h02C00, 0, 1, "R4/R10");
        run_access(20'h3FFFF, 0, 1, "R4/R10");
        run_access(20'hE7FFF, 0, 2, "R4/R10");

        // R5 global wait on all windows
        wr_cs(8'h00);
        wr_mode(8'h80);
        run_access(20'hC0000, 0, 2, "R5");
        run_access(20'h80000, 0, 2, "R5");
        run_access(20'h40000, 0, 2, "R5");
        run_access(20'h02C00, 0, 2, "R5");
        wr_mode(8'h00);

        // R6 multiplexed windows
        s_mux = 4'b0010;
        run_access(20'h80000, 0, 3, "R6");
        wr_cs(8'b0010_0000);
        run_access(20'hA0000, 0, 3, "R6");
        wr_mode(8'h80);
        run_access(20'hBFFFF, 0, 3, "R6");
        wr_mode(8'h00);
        wr_cs(8'h00);

        // R7 ready stretching
        run_access(20'h80000, 1, 3, "R7");
        s_mux = 4'b0000;
        run_access(20'h80000, 2, 1, "R7");
        run_access(20'h90000, 1, 1, "R7");
        wr_cs(8'b1000_0000);
        run_access(20'h02C00, 3, 2, "R7");
        wr_cs(8'h00);

        // R8 ready ignored internally
        run_access(20'h01000, -1, 1, "R8");
        run_access(20'h00100, -1, 2, "R8");
        wr_mode(8'h80);
        run_access(20'hE8000, -1, 2, "R8");
        wr_mode(8'h00);

        // R9 write on the accepting edge applies later
        s_csctl_we = 1'b1; s_csctl_wd = 8'b0001_0000;
        run_access(20'hC0000, 0, 1, "R9");
        run_access(20'hC0000, 0, 2, "R9");
        s_mode_we = 1'b1; s_mode_wd = 8'h80;
        run_access(20'h01000, 0, 1, "R9");
        run_access(20'h01000, 0, 2, "R9");
        wr_mode(8'h00);
        wr_cs(8'h00);

        // R11 request held high: one idle clock between accesses
        cur_tag = "R11";
        s_req = 1'b1; s_addr = 20'h01000;
        tick();
        pulses = 0;
        for (int k = 0; k < 6; k++) begin
            tick();
            if (done_o === 1'b1) pulses++;
        end
        s_req = 1'b0;
        checks++;
        if (pulses != 3) begin
            fails++;
            $display("FAIL R11 done pulses: actual=%0d expected=3", pulses);
        end
        repeat (3) tick();
        finish_run();
    end

endmodule